// File: doc/BRIEF.md
# Software-Trap Call Dispatch Unit

This unit resolves a software-trap call instruction into either an illegal-instruction fault or a redirect into one of two handler tables that sit at fixed offsets from a programmable dispatch base. Bit 7 of the instruction's function field chooses the table. A clear bit 7 selects the kernel-only table. A set bit 7 selects the table open to every mode. The low six bits pick a 64-byte slot within the chosen table. The unit also checks that the function field is well formed and that a caller of a kernel-only entry is running in kernel mode.

For an accepted call the unit drives the redirect target. Bit 0 of the target is set to mark that the handler runs in dispatch mode. When the instruction is non-speculative, the unit also requests two state changes: a write of the next sequential PC into the exception-address register, and a swap to the shadow register bank. On a speculative path the redirect is still produced, because the pipeline discards it if the path is squashed, but the state-changing side effects are held back. An external veto input lets surrounding logic suppress an otherwise legal call. Every result is registered and appears as a one-cycle pulse one clock after the call is presented.

Top module: `trap_dispatch`

## Requirements
- R1: When `call_valid` is high at a rising edge, `out_valid` is high for exactly the following cycle. With no call, and after reset, every output is zero.
- R2: A function field with any bit set outside bit 7 and bits 5..0 (bit 6 and bits 8 and up) raises `fault` and produces no redirect, no exception-address write and no bank swap.
- R3: A kernel-only call (bit 7 = 0) raises `fault` unless `cur_mode` equals the kernel encoding 0. In kernel mode the call is accepted.
- R4: A call open to all modes (bit 7 = 1) is accepted in every `cur_mode` value.
- R5: The redirect target of an accepted kernel-only call is `disp_base + 0x2001 + 64*func_code[5:0]`, modulo 2^32.
- R6: The redirect target of an accepted all-mode call is `disp_base + 0x3001 + 64*func_code[5:0]`, modulo 2^32.
- R7: An accepted, non-vetoed, non-speculative call raises `exc_addr_we` and `bank_swap` together, with `exc_addr_data` equal to `next_pc`.
- R8: An accepted, non-vetoed call with `speculative` high still raises `redirect_valid` with the correct target, but leaves `exc_addr_we` and `bank_swap` low.
- R9: A legal call with `veto` high produces no redirect, no exception-address write, no bank swap and no fault.
- R10: When the field is malformed and the privilege check also fails, a single `fault` is reported. A fault is raised whatever the level of `veto`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_valid | input | 1 | A trap-call instruction is presented this cycle |
| func_code | input | 26 | Function field of the instruction |
| cur_mode | input | 2 | Current processor mode, 0 = kernel |
| disp_base | input | 32 | Dispatch base register value |
| next_pc | input | 32 | Address of the next sequential instruction |
| speculative | input | 1 | The instruction lies on a path not yet committed |
| veto | input | 1 | External request to suppress the call |
| out_valid | output | 1 | Result pulse for the call presented one cycle earlier |
| fault | output | 1 | Illegal-instruction fault |
| redirect_valid | output | 1 | Redirect target is valid |
| redirect_target | output | 32 | Handler address, bit 0 set |
| exc_addr_we | output | 1 | Write strobe for the exception-address register |
| exc_addr_data | output | 32 | Value to write, the captured next PC |
| bank_swap | output | 1 | Request to switch to the shadow register bank |

## Verification
The bench sweeps every low-byte function code against every mode, and every combination of speculation and veto. It then sets each high-order bit of the field by itself to probe validity. An inverted privilege bit would fault all-mode calls and accept kernel-only calls from user mode. A missing bit-6 test would let a malformed code through. A mix-up between the 0x2000 and 0x3000 tables, or a lost bit-0 flag, shows up as a wrong target in every accepted case. A design that gated the redirect on speculation, or let the veto mask a fault, would be caught by the speculative and vetoed-fault cases.

// File: rtl/trap_pkg.sv
package trap_pkg;

    // Function field positions the dispatch logic depends on.
    localparam int IDX_W    = 6;
    localparam int PRIV_BIT = 7;
    localparam int SLOT_SH  = 6;

    typedef struct packed {
        logic             legal;
        logic             kernel_only;
        logic [IDX_W-1:0] idx;
    } trap_decode_t;

endpackage

// File: rtl/trap_decode.sv
module trap_decode
    import trap_pkg::*;
#(
    parameter int FUNC_W      = 26,
    parameter int MODE_W      = 2,
    parameter int KERNEL_MODE = 0
) (
    input  logic [FUNC_W-1:0] func_code,
    input  logic [MODE_W-1:0] cur_mode,
    output trap_decode_t      dec,
    output logic              allowed
);
    localparam logic [FUNC_W-1:0] KEEP_MASK =
        (FUNC_W'(1) << PRIV_BIT) | FUNC_W'((1 << IDX_W) - 1);
    localparam logic [MODE_W-1:0] KMODE = MODE_W'(KERNEL_MODE);

    always_comb begin
        dec.legal       = ((func_code & ~KEEP_MASK) == '0);
        dec.kernel_only = ~func_code[PRIV_BIT];
        dec.idx         = func_code[IDX_W-1:0];
        allowed         = dec.legal && (!dec.kernel_only || (cur_mode == KMODE));
    end
endmodule

// File: rtl/trap_target.sv
module trap_target
    import trap_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter logic [31:0] KTAB_OFS   = 32'h2000,
    parameter logic [31:0] UTAB_OFS   = 32'h3000
) (
    input  logic [ADDR_W-1:0] disp_base,
    input  logic              kernel_only,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] target
);
    // Bit 0 marks dispatch mode in the handler address.
    localparam logic [ADDR_W-1:0] K_START = ADDR_W'(KTAB_OFS) | ADDR_W'(1);
    localparam logic [ADDR_W-1:0] U_START = ADDR_W'(UTAB_OFS) | ADDR_W'(1);

    logic [ADDR_W-1:0] slot_ofs;
    logic [ADDR_W-1:0] tab_start;

    always_comb begin
        slot_ofs  = ADDR_W'(idx) << SLOT_SH;
        tab_start = kernel_only ? K_START : U_START;
        target    = disp_base + tab_start + slot_ofs;
    end
endmodule

// File: rtl/trap_dispatch.sv
module trap_dispatch
    import trap_pkg::*;
#(
    parameter int FUNC_W      = 26,
    parameter int MODE_W      = 2,
    parameter int ADDR_W      = 32,
    parameter int KERNEL_MODE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              call_valid,
    input  logic [FUNC_W-1:0] func_code,
    input  logic [MODE_W-1:0] cur_mode,
    input  logic [ADDR_W-1:0] disp_base,
    input  logic [ADDR_W-1:0] next_pc,
    input  logic              speculative,
    input  logic              veto,
    output logic              out_valid,
    output logic              fault,
    output logic              redirect_valid,
    output logic [ADDR_W-1:0] redirect_target,
    output logic              exc_addr_we,
    output logic [ADDR_W-1:0] exc_addr_data,
    output logic              bank_swap
);
    typedef struct packed {
        logic              vld;
        logic              flt;
        logic              redir;
        logic [ADDR_W-1:0] tgt;
        logic              we;
        logic [ADDR_W-1:0] epc;
        logic              swap;
    } result_t;

    trap_decode_t      dec;
    logic              allowed;
    logic [ADDR_W-1:0] tgt_c;
    result_t           res_d, res_q;

    trap_decode #(
        .FUNC_W(FUNC_W), .MODE_W(MODE_W), .KERNEL_MODE(KERNEL_MODE)
    ) u_dec (
        .func_code(func_code), .cur_mode(cur_mode), .dec(dec), .allowed(allowed)
    );

    trap_target #(.ADDR_W(ADDR_W)) u_tgt (
        .disp_base(disp_base), .kernel_only(dec.kernel_only),
        .idx(dec.idx), .target(tgt_c)
    );

    always_comb begin
        res_d = '0;
        if (call_valid) begin
            res_d.vld = 1'b1;
            if (!allowed) begin
                res_d.flt = 1'b1;
            end else if (!veto) begin
                res_d.redir = 1'b1;
                res_d.tgt   = tgt_c;
                if (!speculative) begin
                    res_d.we   = 1'b1;
                    res_d.epc  = next_pc;
                    res_d.swap = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid       = res_q.vld;
    assign fault           = res_q.flt;
    assign redirect_valid  = res_q.redir;
    assign redirect_target = res_q.tgt;
    assign exc_addr_we     = res_q.we;
    assign exc_addr_data   = res_q.epc;
    assign bank_swap       = res_q.swap;

    // R1
    pulse_follows_call_chk: assert property (@(posedge clk) disable iff (!rst_n)
        call_valid |=> out_valid);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !call_valid |=> !out_valid && !fault && !redirect_valid && !exc_addr_we);
    // R2
    fault_blocks_effects_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !redirect_valid && !exc_addr_we && !bank_swap);
    // R2
    bad_code_faults_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_valid && !dec.legal) |=> fault);
    // R7
    swap_pairs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_addr_we |-> bank_swap && redirect_valid);
    // R8
    spec_no_effects_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_valid && speculative) |=> !exc_addr_we && !bank_swap);
    // R9
    veto_suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_valid && veto) |=> !redirect_valid && !bank_swap);
    // R5
    target_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> (((redirect_target - $past(disp_base)) & ADDR_W'(63)) == ADDR_W'(1)));
endmodule

// File: tb/sim_trap_dispatch.sv
`timescale 1ns/1ps
module sim_trap_dispatch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        call_valid = 1'b0;
    logic [25:0] func_code = '0;
    logic [1:0]  cur_mode = '0;
    logic [31:0] disp_base = '0;
    logic [31:0] next_pc = '0;
    logic        speculative = 1'b0;
    logic        veto = 1'b0;
    logic        out_valid, fault, redirect_valid, exc_addr_we, bank_swap;
    logic [31:0] redirect_target, exc_addr_data;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    trap_dispatch u0 (
        .clk(clk), .rst_n(rst_n), .call_valid(call_valid), .func_code(func_code),
        .cur_mode(cur_mode), .disp_base(disp_base), .next_pc(next_pc),
        .speculative(speculative), .veto(veto), .out_valid(out_valid),
        .fault(fault), .redirect_valid(redirect_valid),
        .redirect_target(redirect_target), .exc_addr_we(exc_addr_we),
        .exc_addr_data(exc_addr_data), .bank_swap(bank_swap)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic do_call(input logic [25:0] f, input logic [1:0] m,
                           input logic [31:0] base, input logic [31:0] npc,
                           input bit spec, input bit vt);
        bit          legal, kon, allow, take, eff;
        logic [31:0] tgt;
        string       tag;
        legal = ((f & ~26'h0BF) == 0);
        kon   = (f[7] == 1'b0);
        allow = legal && (!kon || m == 2'd0);
        take  = allow && !vt;
        eff   = take && !spec;
        tgt   = base + (kon ? 32'h2001 : 32'h3001) + ({26'd0, f[5:0]} * 32'd64);
        if (!legal)             tag = (kon && m != 0) ? "R10" : "R2";
        else if (!allow)        tag = "R3";
        else if (vt)            tag = "R9";
        else if (spec)          tag = "R8";
        else if (!kon && m != 0) tag = "R4";
        else if (kon)           tag = "R5";
        else                    tag = "R6";
        call_valid = 1'b1; func_code = f; cur_mode = m; disp_base = base;
        next_pc = npc; speculative = spec; veto = vt;
        @(negedge clk);
        call_valid = 1'b0;
        chk("R1", "out_valid", {31'd0, out_valid}, 32'd1);
        chk(tag, "fault", {31'd0, fault}, {31'd0, !allow});
        chk(tag, "redirect_valid", {31'd0, redirect_valid}, {31'd0, take});
        if (take) chk(kon ? "R5" : "R6", "target", redirect_target, tgt);
        chk(tag, "exc_addr_we", {31'd0, exc_addr_we}, {31'd0, eff});
        chk(tag, "bank_swap", {31'd0, bank_swap}, {31'd0, eff});
        if (eff) chk("R7", "exc_addr_data", exc_addr_data, npc);
    endtask

    task automatic idle_check();
        call_valid = 1'b0;
        @(negedge clk);
        chk("R1", "idle out_valid", {31'd0, out_valid}, 32'd0);
        chk("R1", "idle redirect", {31'd0, redirect_valid}, 32'd0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int n = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "reset out_valid", {31'd0, out_valid}, 32'd0);
        chk("R1", "reset fault", {31'd0, fault}, 32'd0);
        chk("R1", "reset exc_addr_we", {31'd0, exc_addr_we}, 32'd0);
        rst_n = 1'b1;
        idle_check();
        // Full sweep of the low byte against modes, speculation, veto
        for (int m = 0; m < 4; m++) begin
            for (int f = 0; f < 256; f++) begin
                for (int sv = 0; sv < 4; sv++) begin
                    logic [31:0] base;
                    base = 32'hFFFF_C000 ^ (32'(f) << 18) ^ (32'(m) << 9) ^ 32'(sv * 12);
                    do_call(26'(f), 2'(m), base, 32'h0010_0000 + 32'(n * 4),
                            sv[0], sv[1]);
                    n++;
                end
            end
            idle_check();
        end
        // R2 / R10: each upper bit set alone, with kernel-only and all-mode codes
        for (int b = 8; b < 26; b++) begin
            for (int m = 0; m < 4; m++) begin
                do_call((26'd1 << b) | 26'h05, 2'(m), 32'h0000_8000, 32'h100, 1'b0, 1'b1);
                do_call((26'd1 << b) | 26'h85, 2'(m), 32'h0000_8000, 32'h104, 1'b0, 1'b0);
            end
        end
        // R10: malformed and privilege violation, veto high, single fault
        do_call(26'h3FFFF7F, 2'd3, 32'h1234_5678, 32'h200, 1'b1, 1'b1);
        // R5 wrap-around at top of address space
        do_call(26'h03F, 2'd0, 32'hFFFF_F000, 32'h300, 1'b0, 1'b0);
        idle_check();
        finish_run();
    end
endmodule